// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a simple request source and a four-bank double-data-rate SDRAM with a 4096-row array. It takes read, write and optional auto-precharge requests on a valid/ready port and turns them into the command pins of the memory: chip select, the three strobes, the bank select and the address bus. It remembers which row is open in each bank, so a request to an open row goes out as a single column command. A request to a different row first closes the old row and then opens the new one.

After reset the sequencer runs the power-up routine on its own. It then keeps the array alive with periodic auto refresh and tells the data path when read data and write data beats are due. The request port is back-pressured: `req_ready` is high only when the sequencer is idle, all of its timing gaps have run out and no refresh is waiting. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The payload is sampled on that edge only. A source may keep `req_valid` high for as long as it likes, and no request is lost or taken twice.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is held, the command pins show NOP ({cs_n,ras_n,cas_n,we_n}=0111), and `req_ready`, `rd_valid` and `wr_valid` are low.
- R2: After reset the pins carry, in this order: precharge-all (the auto-precharge address bit set), an extended mode load (bank 1, address 0), a base mode load with the DLL-reset bit A8 set, two auto refreshes spaced T_RFC apart, and a base mode load with A8 clear. `req_ready` first rises T_MRD-1 cycles after that last load.
- R3: The mode word carries the burst length code in A2:A0 (2→1, 4→2, 8→3), the interleave flag in A3, and the CAS latency code in A6:A4 (2→2, 2.5→6, 3→3, 4→4).
- R4: A request to a closed bank issues ACTIVE (bank, row on A11:A0) on the acceptance edge, followed by the column command exactly T_RCD cycles later.
- R5: A request to the row already open in its bank issues its column command on the acceptance edge, with no ACTIVE.
- R6: A request that finds a different row open issues PRECHARGE on that bank with the auto-precharge bit clear, then ACTIVE T_RP cycles later, then the column command T_RCD cycles after that.
- R7: Column commands put the column on the low address bits, and when auto-precharge is requested they set A8 (32-bit data) or A10 (16-bit data). That bank then counts as closed, so the next request to the same row issues ACTIVE again.
- R8: A refresh falls due every CLK_MHZ*1000*REF_MS/4096 cycles. If any bank is open, precharge-all goes out first and AUTO REFRESH follows T_RP cycles later. If no bank is open, AUTO REFRESH goes out at once. Afterwards every bank counts as closed.
- R9: `req_ready` stays low while a command sequence or timing gap is in progress and while a refresh is pending. A request held valid through that time is accepted exactly once.
- R10: `rd_valid` is high for BURST_LEN/2 cycles, starting floor(CL) cycles after the READ command appears. `rd_half` is high when the CAS latency has a half cycle.
- R11: `wr_valid` is high for BURST_LEN/2 cycles, starting one cycle after the WRITE command appears.
- R12: A READ or WRITE is first accepted by the command issued on the acceptance edge, and no command follows a column command for BURST_LEN/2 cycles, or BURST_LEN/2+T_RP cycles with auto-precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after the column command |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column (8 bits for 32-bit data, 9 for 16-bit data) |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank select |
| ddr_addr | output | ROW_W | Multiplexed address bus |
| rd_valid | output | 1 | Read data beats due this cycle |
| rd_half | output | 1 | CAS latency includes a half cycle |
| wr_valid | output | 1 | Write data beats due this cycle |

## Verification
The request stream covers four bank situations, and each one tells the three access paths apart by which commands reach the pins and how far apart they are: a closed bank, a hit on the open row, a conflict with another row, and a revisit after an auto-precharge. A request is held valid while the sequencer is busy, to show that one request is taken exactly once. The bench lets the refresh timer expire twice, once with rows open and once with all banks closed. This separates the precharge-first path from the direct refresh, and the distance between the two refreshes confirms the interval. The read and write due windows are compared cycle by cycle against the command times seen on the pins.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_EMRS, ST_MRS1, ST_REF1, ST_REF2, ST_MRS2,
    ST_IDLE, ST_REF, ST_ACT, ST_COL
  } seq_state_e;

  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      2:       return 3'd1;
      8:       return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  // latency given in half cycles
  function automatic logic [2:0] latency_code(input int half_cycles);
    case (half_cycles)
      4:       return 3'b010;
      5:       return 3'b110;
      8:       return 3'b100;
      default: return 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  localparam int BANKS = 2 ** BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic [BA_W-1:0]  act_bank,
  input  logic [ROW_W-1:0] act_row,
  input  logic             cls_en,
  input  logic [BA_W-1:0]  cls_bank,
  input  logic             cls_all,
  input  logic [BA_W-1:0]  q_bank,
  output logic             q_open,
  output logic [ROW_W-1:0] q_row,
  output logic             any_open
);
  logic [BANKS-1:0] open_v;
  logic [ROW_W-1:0] rows [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_v[b] <= 1'b0;
        rows[b]   <= '0;
      end else if (cls_all) begin
        open_v[b] <= 1'b0;
      end else if (act_en && act_bank == BA_W'(b)) begin
        open_v[b] <= 1'b1;
        rows[b]   <= act_row;
      end else if (cls_en && cls_bank == BA_W'(b)) begin
        open_v[b] <= 1'b0;
      end
    end
  end

  assign q_open   = open_v[q_bank];
  assign q_row    = rows[q_bank];
  assign any_open = |open_v;
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int INTERVAL = 3906,
  localparam int RW = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  logic [RW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == RW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!run || wrap) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      if (wrap)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_data_due.sv
module ddr_data_due #(
  parameter int LAT   = 2,
  parameter int BEATS = 2,
  localparam int BW = $clog2(BEATS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic due
);
  logic [LAT-1:0] pipe;
  logic [BW-1:0]  beats_left;

  if (LAT == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= issue;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[LAT-2:0], issue};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 beats_left <= '0;
    else if (pipe[LAT-1])       beats_left <= BW'(BEATS);
    else if (beats_left != '0)  beats_left <= beats_left - 1'b1;
  end

  assign due = (beats_left != '0);
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int DQ_WIDTH  = 32,
  parameter int ROW_W     = 12,
  parameter int BA_W      = 2,
  parameter int CLK_MHZ   = 250,
  parameter int REF_MS    = 64,
  parameter int T_PWRUP   = 50000,
  parameter int T_RP      = 5,
  parameter int T_RCD     = 5,
  parameter int T_RFC     = 18,
  parameter int T_MRD     = 2,
  parameter int CAS_X2    = 6,
  parameter int BURST_LEN = 4,
  parameter bit BURST_IL  = 1'b0,
  localparam int COL_W    = (DQ_WIDTH == 32) ? 8 : 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_autopre,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             ddr_cs_n,
  output logic             ddr_ras_n,
  output logic             ddr_cas_n,
  output logic             ddr_we_n,
  output logic [BA_W-1:0]  ddr_ba,
  output logic [ROW_W-1:0] ddr_addr,
  output logic             rd_valid,
  output logic             rd_half,
  output logic             wr_valid
);
  localparam int AP_BIT  = (DQ_WIDTH == 32) ? 8 : 10;
  localparam int DLL_BIT = 8;
  localparam int ROWS    = 2 ** ROW_W;
  localparam int T_REFI  = CLK_MHZ * 1000 * REF_MS / ROWS;
  localparam int BEATS   = BURST_LEN / 2;
  localparam int CL_INT  = CAS_X2 / 2;
  localparam int CW      = $clog2(T_PWRUP + T_RFC + T_RP + T_RCD + T_MRD + BEATS + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({latency_code(CAS_X2), BURST_IL, burst_code(BURST_LEN)});

  seq_state_e state, n_state;
  logic [CW-1:0] wait_cnt, n_wait;
  ddr_cmd_e cmd_q, n_cmd;
  logic [BA_W-1:0]  ba_q, n_ba;
  logic [ROW_W-1:0] addr_q, n_addr;
  logic init_done, done_set;

  logic             lat_write, lat_ap;
  logic [BA_W-1:0]  lat_bank;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;

  logic             cur_write, cur_ap;
  logic [BA_W-1:0]  cur_bank;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  logic fire, act_en, cls_en, cls_all, ref_ack, ref_pend;
  logic q_open, any_open, row_hit;
  logic [ROW_W-1:0] q_row;

  // request currently being worked on: fresh in idle, latched otherwise
  always_comb begin
    if (state == ST_IDLE) begin
      cur_write = req_write;  cur_ap  = req_autopre;
      cur_bank  = req_bank;   cur_row = req_row;   cur_col = req_col;
    end else begin
      cur_write = lat_write;  cur_ap  = lat_ap;
      cur_bank  = lat_bank;   cur_row = lat_row;   cur_col = lat_col;
    end
  end

  ddr_bank_table #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_en), .act_bank(cur_bank), .act_row(cur_row),
    .cls_en(cls_en), .cls_bank(cur_bank), .cls_all(cls_all),
    .q_bank(cur_bank), .q_open(q_open), .q_row(q_row), .any_open(any_open)
  );

  ddr_refresh_timer #(.INTERVAL(T_REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .pending(ref_pend)
  );

  assign row_hit   = q_open && (q_row == cur_row);
  assign req_ready = (state == ST_IDLE) && (wait_cnt == '0) && !ref_pend;

  always_comb begin
    n_cmd    = CMD_NOP;
    n_ba     = '0;
    n_addr   = '0;
    n_state  = state;
    n_wait   = wait_cnt;
    act_en   = 1'b0;
    cls_en   = 1'b0;
    cls_all  = 1'b0;
    ref_ack  = 1'b0;
    done_set = 1'b0;
    fire     = 1'b0;
    if (wait_cnt != '0) begin
      n_wait = wait_cnt - 1'b1;
    end else begin
      case (state)
        ST_PWR: begin
          n_cmd = CMD_PRE;  n_addr[AP_BIT] = 1'b1;  cls_all = 1'b1;
          n_wait = CW'(T_RP - 1);  n_state = ST_EMRS;
        end
        ST_EMRS: begin
          n_cmd = CMD_MRS;  n_ba = BA_W'(1);
          n_wait = CW'(T_MRD - 1);  n_state = ST_MRS1;
        end
        ST_MRS1: begin
          n_cmd = CMD_MRS;  n_addr = MODE_WORD;  n_addr[DLL_BIT] = 1'b1;
          n_wait = CW'(T_MRD - 1);  n_state = ST_REF1;
        end
        ST_REF1: begin
          n_cmd = CMD_REF;  n_wait = CW'(T_RFC - 1);  n_state = ST_REF2;
        end
        ST_REF2: begin
          n_cmd = CMD_REF;  n_wait = CW'(T_RFC - 1);  n_state = ST_MRS2;
        end
        ST_MRS2: begin
          n_cmd = CMD_MRS;  n_addr = MODE_WORD;  done_set = 1'b1;
          n_wait = CW'(T_MRD - 1);  n_state = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            if (any_open) begin
              n_cmd = CMD_PRE;  n_addr[AP_BIT] = 1'b1;  cls_all = 1'b1;
              n_wait = CW'(T_RP - 1);  n_state = ST_REF;
            end else begin
              n_cmd = CMD_REF;  ref_ack = 1'b1;
              n_wait = CW'(T_RFC - 1);
            end
          end else if (req_valid) begin
            fire = 1'b1;
            if (row_hit) begin
              n_cmd  = cur_write ? CMD_WR : CMD_RD;
              n_ba   = cur_bank;
              n_addr = ROW_W'(cur_col);
              if (cur_ap) begin
                n_addr[AP_BIT] = 1'b1;  cls_en = 1'b1;
                n_wait = CW'(BEATS + T_RP - 1);
              end else begin
                n_wait = CW'(BEATS - 1);
              end
            end else if (q_open) begin
              n_cmd = CMD_PRE;  n_ba = cur_bank;  cls_en = 1'b1;
              n_wait = CW'(T_RP - 1);  n_state = ST_ACT;
            end else begin
              n_cmd = CMD_ACT;  n_ba = cur_bank;  n_addr = cur_row;  act_en = 1'b1;
              n_wait = CW'(T_RCD - 1);  n_state = ST_COL;
            end
          end
        end
        ST_REF: begin
          n_cmd = CMD_REF;  ref_ack = 1'b1;
          n_wait = CW'(T_RFC - 1);  n_state = ST_IDLE;
        end
        ST_ACT: begin
          n_cmd = CMD_ACT;  n_ba = cur_bank;  n_addr = cur_row;  act_en = 1'b1;
          n_wait = CW'(T_RCD - 1);  n_state = ST_COL;
        end
        ST_COL: begin
          n_cmd  = cur_write ? CMD_WR : CMD_RD;
          n_ba   = cur_bank;
          n_addr = ROW_W'(cur_col);
          n_state = ST_IDLE;
          if (cur_ap) begin
            n_addr[AP_BIT] = 1'b1;  cls_en = 1'b1;
            n_wait = CW'(BEATS + T_RP - 1);
          end else begin
            n_wait = CW'(BEATS - 1);
          end
        end
        default: n_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWR;
      wait_cnt  <= CW'(T_PWRUP);
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      init_done <= 1'b0;
      lat_write <= 1'b0;
      lat_ap    <= 1'b0;
      lat_bank  <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
    end else begin
      state    <= n_state;
      wait_cnt <= n_wait;
      cmd_q    <= n_cmd;
      ba_q     <= n_ba;
      addr_q   <= n_addr;
      if (done_set) init_done <= 1'b1;
      if (fire) begin
        lat_write <= req_write;
        lat_ap    <= req_autopre;
        lat_bank  <= req_bank;
        lat_row   <= req_row;
        lat_col   <= req_col;
      end
    end
  end

  ddr_data_due #(.LAT(CL_INT), .BEATS(BEATS)) u_rd_due (
    .clk(clk), .rst_n(rst_n), .issue(n_cmd == CMD_RD), .due(rd_valid)
  );

  ddr_data_due #(.LAT(1), .BEATS(BEATS)) u_wr_due (
    .clk(clk), .rst_n(rst_n), .issue(n_cmd == CMD_WR), .due(wr_valid)
  );

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
  assign ddr_ba   = ba_q;
  assign ddr_addr = addr_q;
  assign rd_half  = CAS_X2[0];
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int CLF = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       wr_valid,
  input logic       any_open
);
  // R10: a read window opens only CL cycles after a READ on the pins
  p_rd_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(cmd == 4'b0101, CLF));

  // R11: a write window opens one cycle after a WRITE on the pins
  p_wr_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(cmd == 4'b0100));

  // R12: an accepted request drives a real command on the next cycle
  p_accept_acts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd != 4'b0111));

  // R8: auto refresh only with every bank closed
  p_refresh_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> !any_open);
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(.CLF(CAS_X2 / 2)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}),
  .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .wr_valid(wr_valid), .any_open(any_open)
);

// File: tb/ddr_cmd_seq_bench.sv
`timescale 1ns/1ps
module ddr_cmd_seq_bench;
  localparam int T_RP = 3, T_RCD = 3, T_RFC = 8, T_MRD = 2;
  localparam int CAS_X2 = 5, BL = 4, BEATS = 2, CLF = 2;
  localparam int T_REFI = 250 * 1000 * 16 / 4096;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_autopre = 0;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [7:0] req_col = 0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_valid, rd_half, wr_valid;
  logic [1:0] ba;
  logic [11:0] addr;

  always #2 clk = ~clk;

  ddr_cmd_seq #(.DQ_WIDTH(32), .CLK_MHZ(250), .REF_MS(16), .T_PWRUP(20),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .CAS_X2(CAS_X2), .BURST_LEN(BL), .BURST_IL(1'b1)) u_ddr_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .ddr_cs_n(cs_n), .ddr_ras_n(ras_n),
    .ddr_cas_n(cas_n), .ddr_we_n(we_n), .ddr_ba(ba), .ddr_addr(addr),
    .rd_valid(rd_valid), .rd_half(rd_half), .wr_valid(wr_valid));

  typedef struct {
    logic [3:0] cmd; logic [1:0] ba; logic [11:0] addr;
    bit cba; bit caddr; bit at_hs; int gap; string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int cyc = 0, hs_cyc = -1, last_cyc = 0, mrs_cyc = 0;
  int last_rd = -100, prev_rd = -100, last_wr = -100, prev_wr = -100;
  int ref_cycs[$];
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic expect_cmd(input logic [3:0] c, input logic [1:0] b,
      input logic [11:0] a, input bit cb, input bit ca, input bit hs,
      input int gap, input string tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.cba = cb; e.caddr = ca;
    e.at_hs = hs; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send(input bit wr, input bit ap, input logic [1:0] b,
                      input logic [11:0] r, input logic [7:0] c);
    @(negedge clk);
    req_write = wr; req_autopre = ap; req_bank = b; req_row = r; req_col = c;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    hs_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 0; req_row = 12'hABC; req_col = 8'h5A; req_bank = 2'd2;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit in_win(input int c, input int start, input int lat);
    return (c >= start + lat) && (c < start + lat + BEATS);
  endfunction

  // monitor: pops expected commands and checks data-due windows
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] c;
      bit er, ew;
      c = {cs_n, ras_n, cas_n, we_n};
      er = in_win(cyc, last_rd, CLF) || in_win(cyc, prev_rd, CLF);
      ew = in_win(cyc, last_wr, 1) || in_win(cyc, prev_wr, 1);
      if (er || rd_valid) check(rd_valid == er, "R10", "rd_valid", rd_valid, er);
      if (ew || wr_valid) check(wr_valid == ew, "R11", "wr_valid", wr_valid, ew);
      if (c != NOP) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected command", c, NOP);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(c == e.cmd, e.tag, "command", c, e.cmd);
          if (e.cba) check(ba == e.ba, e.tag, "bank", ba, e.ba);
          if (e.caddr) check(addr == e.addr, e.tag, "address", addr, e.addr);
          if (e.gap >= 0) check(cyc - last_cyc == e.gap, e.tag, "gap", cyc - last_cyc, e.gap);
          if (e.at_hs) check(cyc == hs_cyc, e.tag, "issue cycle", cyc, hs_cyc);
        end
        last_cyc = cyc;
        if (c == MRS) mrs_cyc = cyc;
        if (c == REF) ref_cycs.push_back(cyc);
        if (c == RD) begin prev_rd = last_rd; last_rd = cyc; end
        if (c == WR) begin prev_wr = last_wr; last_wr = cyc; end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int first_ready;
    // R1: reset state
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "cmd in reset", {cs_n, ras_n, cas_n, we_n}, NOP);
    check(req_ready == 0, "R1", "ready in reset", req_ready, 0);
    check(rd_valid == 0 && wr_valid == 0, "R1", "due in reset", {rd_valid, wr_valid}, 0);
    check(rd_half == 1, "R10", "half-cycle latency flag", rd_half, 1);

    // R2, R3: init order; mode word BL4=2, interleave, CL2.5=6 -> 0x06A
    expect_cmd(PRE, 0, 12'h100, 0, 1, 0, -1, "R2");
    expect_cmd(MRS, 1, 12'h000, 1, 1, 0, T_RP, "R2");
    expect_cmd(MRS, 0, 12'h16A, 1, 1, 0, T_MRD, "R3");
    expect_cmd(REF, 0, 0, 0, 0, 0, T_MRD, "R2");
    expect_cmd(REF, 0, 0, 0, 0, 0, T_RFC, "R2");
    expect_cmd(MRS, 0, 12'h06A, 1, 1, 0, T_RFC, "R3");
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    first_ready = cyc;
    check(first_ready == mrs_cyc + T_MRD - 1, "R2", "first ready cycle", first_ready, mrs_cyc + T_MRD - 1);

    // R4 + R11: write to closed bank
    expect_cmd(ACT, 0, 12'h005, 1, 1, 1, -1, "R4");
    expect_cmd(WR, 0, 12'h010, 1, 1, 0, T_RCD, "R4");
    send(1, 0, 0, 12'h005, 8'h10);
    // R5: hit on open row
    expect_cmd(RD, 0, 12'h022, 1, 1, 1, -1, "R5");
    send(0, 0, 0, 12'h005, 8'h22);
    // R6 + R7: conflict, read with auto-precharge (A8)
    expect_cmd(PRE, 0, 12'h000, 1, 1, 1, -1, "R6");
    expect_cmd(ACT, 0, 12'h009, 1, 1, 0, T_RP, "R6");
    expect_cmd(RD, 0, 12'h101, 1, 1, 0, T_RCD, "R7");
    send(0, 1, 0, 12'h009, 8'h01);
    // R7: bank closed after auto-precharge; R12 gap BEATS+T_RP
    expect_cmd(ACT, 0, 12'h009, 1, 1, 1, BEATS + T_RP, "R7");
    expect_cmd(RD, 0, 12'h002, 1, 1, 0, T_RCD, "R7");
    send(0, 0, 0, 12'h009, 8'h02);
    // R4 + R7: write edge row/col with auto-precharge
    expect_cmd(ACT, 3, 12'hFFF, 1, 1, 1, -1, "R4");
    expect_cmd(WR, 3, 12'h1FF, 1, 1, 0, T_RCD, "R7");
    send(1, 1, 3, 12'hFFF, 8'hFF);
    // R9: second request held while busy, accepted once; R12 spacing
    expect_cmd(ACT, 1, 12'h007, 1, 1, 1, -1, "R9");
    expect_cmd(RD, 1, 12'h003, 1, 1, 0, T_RCD, "R9");
    send(0, 0, 1, 12'h007, 8'h03);
    expect_cmd(RD, 1, 12'h004, 1, 1, 1, BEATS, "R12");
    send(0, 0, 1, 12'h007, 8'h04);

    // R8: refresh with banks open -> precharge-all then refresh
    expect_cmd(PRE, 0, 12'h100, 0, 1, 0, -1, "R8");
    expect_cmd(REF, 0, 0, 0, 0, 0, T_RP, "R8");
    repeat (1100) @(negedge clk);
    // R8: next refresh with all banks closed -> refresh alone
    expect_cmd(REF, 0, 0, 0, 0, 0, -1, "R8");
    repeat (1050) @(negedge clk);
    if (ref_cycs.size() >= 4)
      check(ref_cycs[3] - ref_cycs[2] == T_REFI - T_RP, "R8", "refresh spacing",
            ref_cycs[3] - ref_cycs[2], T_REFI - T_RP);
    else
      check(0, "R8", "refresh count", ref_cycs.size(), 4);
    // R8: rows closed by refresh -> ACT needed again
    expect_cmd(ACT, 1, 12'h007, 1, 1, 1, -1, "R8");
    expect_cmd(RD, 1, 12'h005, 1, 1, 0, T_RCD, "R8");
    send(0, 0, 1, 12'h007, 8'h05);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R12", "expected commands left", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule